// File: doc/BRIEF.md
# E1 Service Word Bit Handler

This block processes the service-word bits that an E1 link carries in timeslot 0 of every frame that holds no frame alignment signal: the remote alarm bit and the five national bits. It sees one timeslot-0 byte per frame, in both directions. A frame counter inside the block counts 16 frames. It gives each frame an index, and that index tells the frames that carry the alignment signal (even) from the frames that carry the service word (odd). The national bits are kept in 8-bit registers indexed by this count. No CRC multiframe alignment is searched for and no CRC bits are generated.

On receive, the block reads the remote alarm bit and raises a sticky alarm status. It collects the national bits into shadow registers and copies all of them to the outputs at the end of each 16-frame cycle. On transmit, it builds the outgoing service word. The remote alarm bit comes from one of three sources: the system-side byte (transparent), a manual request, or an automatic rule that follows loss of frame alignment. The national bits come from transmit registers. Frame alignment is done elsewhere and is reported to this block as the `lfa` and `frm_zero` inputs.

Top module: `e1_svc_bits`

## Requirements
- R1: After reset, `tx_ts0`, `rx_sa` and `ra_stat` are all zero.
- R2: A `fr_tick` with `frm_zero` high is frame index 0. Each later tick without `frm_zero` adds one to the index, and the index wraps from 15 to 0. Odd indices are service-word frames.
- R3: On a tick for an even frame, `tx_ts0` takes the value of `sys_ts0` in the next cycle.
- R4: On a tick for an odd frame, the next `tx_ts0` has bit [7] (slot bit 1) copied from `sys_ts0[7]` and bit [6] (slot bit 2) forced to 1.
- R5: In odd frames, the remote alarm bit `tx_ts0[5]` (slot bit 3) is chosen in this order. If `a_transp` is high, it is `sys_ts0[5]`. Otherwise, if `xra` is high, it is 1. Otherwise, if `axra` and `lfa` are both high, it is 1. In every other case it is 0.
- R6: In odd frame k, with `sa_en` high, `tx_ts0[p]` (p=0 for Sa8 up to p=4 for Sa4) is `tx_sa[8*p + 7 - k/2]`, so frame 1 uses the MSB. With `sa_en` low, these bits are copied from `sys_ts0[p]`.
- R7: With `sa_en` high and `lfa` low, the bit `rx_ts0[p]` of odd frame k is stored at position `8*p + 7 - k/2`. One cycle after the tick for frame 15, `rx_sa` shows all 40 bits of that cycle.
- R8: `rx_sa` changes only in the cycle after a frame-15 tick with `sa_en` high. It holds its value at every other time.
- R9: A tick for an odd frame with `rx_ts0[5]` = 1 and `lfa` low sets `ra_stat` in the next cycle. A 1 in that bit position of an even frame, or any frame received while `lfa` is high, does not set it.
- R10: `ra_stat` stays set until `ra_ack` is high for one cycle. If a set and an acknowledge happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_tick | input | 1 | One-cycle strobe per frame; the timeslot-0 bytes are valid |
| frm_zero | input | 1 | Marks the ticked frame as index 0 |
| rx_ts0 | input | 8 | Received timeslot-0 byte, slot bit 1 at [7] |
| sys_ts0 | input | 8 | System-side timeslot-0 byte for transmit |
| sa_en | input | 1 | Enables the national-bit registers |
| lfa | input | 1 | Receiver has lost frame alignment |
| xra | input | 1 | Manual remote alarm request |
| axra | input | 1 | Automatic remote alarm on loss of alignment |
| a_transp | input | 1 | Remote alarm bit taken from the system side |
| ra_ack | input | 1 | Clears the remote alarm status |
| tx_sa | input | 40 | Transmit national bits, Sa4 at [39:32] down to Sa8 at [7:0] |
| tx_ts0 | output | 8 | Transmitted timeslot-0 byte, registered |
| rx_sa | output | 40 | Received national bits, same layout as `tx_sa` |
| ra_stat | output | 1 | Sticky remote alarm status |

## Verification
The case that is hardest to reach from the ports is the link between the frame index and the register bit positions. One wrong bit shows up only after a full 16-frame cycle, and only if each odd frame carries a different bit. The bench therefore sends several complete cycles. Each cycle uses arithmetic byte patterns that differ from frame to frame, and the bench builds the 40-bit expected word from those bytes. For the alarm source priority, the bench walks through all 32 combinations of the three controls, `lfa` and the system-side bit, once with the national-bit registers enabled and once with them disabled, and checks every transmitted byte of each cycle.

// File: rtl/e1_svc_bits.sv
module e1_svc_bits #(
  parameter int NSA    = 5,
  parameter int FRAMES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fr_tick,
  input  logic                        frm_zero,
  input  logic [7:0]                  rx_ts0,
  input  logic [7:0]                  sys_ts0,
  input  logic                        sa_en,
  input  logic                        lfa,
  input  logic                        xra,
  input  logic                        axra,
  input  logic                        a_transp,
  input  logic                        ra_ack,
  input  logic [NSA*(FRAMES/2)-1:0]   tx_sa,
  output logic [7:0]                  tx_ts0,
  output logic [NSA*(FRAMES/2)-1:0]   rx_sa,
  output logic                        ra_stat
);
  localparam int IW = $clog2(FRAMES);
  localparam int SW = FRAMES / 2;
  localparam int RW = NSA * SW;
  localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);

  logic [IW-1:0]   cnt, cur;
  logic [IW-2:0]   slot;
  logic            odd, a_bit, ra_hit, wrap;
  logic [7:0]      tx_nxt;
  logic [RW-1:0]   shadow, sh_nxt;

  assign cur    = frm_zero ? '0 : cnt;
  assign odd    = cur[0];
  assign slot   = cur[IW-1:1];
  assign a_bit  = a_transp ? sys_ts0[5] : (xra | (axra & lfa));
  assign ra_hit = fr_tick & odd & ~lfa & rx_ts0[5];
  assign wrap   = fr_tick & sa_en & (cur == LAST);

  always_comb begin
    tx_nxt = sys_ts0;
    if (odd) begin
      tx_nxt[6] = 1'b1;
      tx_nxt[5] = a_bit;
      if (sa_en)
        for (int p = 0; p < NSA; p++)
          tx_nxt[p] = tx_sa[p*SW + (SW-1) - int'(slot)];
    end
  end

  always_comb begin
    sh_nxt = shadow;
    if (odd && sa_en && !lfa)
      for (int p = 0; p < NSA; p++)
        sh_nxt[p*SW + (SW-1) - int'(slot)] = rx_ts0[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_ts0  <= '0;
      shadow  <= '0;
      rx_sa   <= '0;
      ra_stat <= 1'b0;
    end else begin
      if (fr_tick) begin
        cnt    <= cur + 1'b1;
        tx_ts0 <= tx_nxt;
        shadow <= sh_nxt;
      end
      if (wrap) rx_sa <= sh_nxt;
      if (ra_hit)      ra_stat <= 1'b1;
      else if (ra_ack) ra_stat <= 1'b0;
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && !frm_zero && cnt == LAST |=> cnt == '0); // R2
  AST_EVEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && !odd |=> tx_ts0 == $past(sys_ts0)); // R3
  AST_ODD_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && odd |=> tx_ts0[6]); // R4
  AST_A_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && odd && !a_transp && xra |=> tx_ts0[5]); // R5
  AST_A_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && odd && !a_transp && !xra && !(axra && lfa) |=> !tx_ts0[5]); // R5
  AST_RXSA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(rx_sa)); // R8
  AST_RA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fr_tick && odd && !lfa && rx_ts0[5] |=> ra_stat); // R9
  AST_RA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ra_stat && !ra_ack |=> ra_stat); // R10
endmodule

// File: tb/tb_e1_svc_bits.sv
module tb_e1_svc_bits;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fr_tick = 0, frm_zero = 0, sa_en = 0, lfa = 0, xra = 0, axra = 0, a_transp = 0, ra_ack = 0;
  logic [7:0] rx_ts0 = 0, sys_ts0 = 0;
  logic [39:0] tx_sa = 0;
  logic [7:0] tx_ts0;
  logic [39:0] rx_sa;
  logic ra_stat;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  e1_svc_bits dut (.clk(clk), .rst_n(rst_n), .fr_tick(fr_tick), .frm_zero(frm_zero),
    .rx_ts0(rx_ts0), .sys_ts0(sys_ts0), .sa_en(sa_en), .lfa(lfa), .xra(xra), .axra(axra),
    .a_transp(a_transp), .ra_ack(ra_ack), .tx_sa(tx_sa), .tx_ts0(tx_ts0), .rx_sa(rx_sa),
    .ra_stat(ra_stat));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(bit zero, logic [7:0] rx, logic [7:0] sys);
    @(negedge clk);
    fr_tick = 1; frm_zero = zero; rx_ts0 = rx; sys_ts0 = sys;
    @(negedge clk);
    fr_tick = 0; frm_zero = 0;
  endtask

  function automatic logic [7:0] exp_tx(int k, logic [7:0] sys);
    logic [7:0] b = sys;
    if (k % 2 == 1) begin
      b[6] = 1'b1;
      b[5] = a_transp ? sys[5] : (xra | (axra & lfa));
      if (sa_en) for (int p = 0; p < 5; p++) b[p] = tx_sa[8*p + 7 - k/2];
    end
    return b;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [39:0] exp_sh, exp_rx;
    logic [7:0] sys, rx;
    repeat (3) @(negedge clk);
    chk("R1 tx", tx_ts0, 0); chk("R1 rx_sa", rx_sa, 0); chk("R1 ra", ra_stat, 0);
    rst_n = 1;

    // R3 R4 R5 R6 R2: transmit sweep over all control combinations
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 32; c++) begin
        sa_en = en[0]; a_transp = c[0]; xra = c[1]; axra = c[2]; lfa = c[3];
        tx_sa = {8'(c*7+1), 8'(c*13+5), 8'(c*29+3), 8'(c*3+9), 8'(c*17+11)};
        for (int k = 0; k < 16; k++) begin
          sys = 8'(k*37 + c*11 + en*5);
          sys[5] = c[4];
          tick(k == 0 && c == 0, 8'h00, sys);
          chk(k % 2 ? "R4 R5 R6 odd" : "R3 R2 even", tx_ts0, exp_tx(k, sys));
        end
      end
    lfa = 0; xra = 0; axra = 0; a_transp = 0;

    // R7 R8: receive capture over several cycles
    sa_en = 1; exp_sh = 0; exp_rx = rx_sa;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 16; k++) begin
        rx = 8'(k*53 + m*29 + 7);
        tick(m == 0 && k == 0, rx, 8'h00);
        if (k % 2) for (int p = 0; p < 5; p++) exp_sh[8*p + 7 - k/2] = rx[p];
        if (k == 15) exp_rx = exp_sh;
        chk(k == 15 ? "R7 latch" : "R8 hold", rx_sa, exp_rx);
      end
    // R8: disabled registers hold
    sa_en = 0;
    for (int k = 0; k < 16; k++) begin
      tick(k == 0, 8'(k*91 + 3), 8'h00);
      chk("R8 sa_en low hold", rx_sa, exp_rx);
    end

    // R9 R10: remote alarm status
    @(negedge clk); ra_ack = 1; @(negedge clk); ra_ack = 0;
    chk("R10 ack clears", ra_stat, 0);
    tick(1, 8'h20, 8'h00);
    chk("R9 even frame ignored", ra_stat, 0);
    lfa = 1; tick(0, 8'h20, 8'h00); lfa = 0;
    chk("R9 lfa suppresses", ra_stat, 0);
    tick(0, 8'h00, 8'h00);
    tick(0, 8'h20, 8'h00);
    chk("R9 set on odd frame", ra_stat, 1);
    repeat (3) @(negedge clk);
    chk("R10 sticky", ra_stat, 1);
    tick(0, 8'h00, 8'h00);
    tick(0, 8'h00, 8'h00);
    chk("R10 sticky on A=0", ra_stat, 1);
    @(negedge clk); ra_ack = 1; @(negedge clk); ra_ack = 0;
    chk("R10 ack clears", ra_stat, 0);
    tick(0, 8'h00, 8'h00);
    @(negedge clk); fr_tick = 1; rx_ts0 = 8'h20; ra_ack = 1;
    @(negedge clk); fr_tick = 0; ra_ack = 0;
    chk("R10 set wins", ra_stat, 1);

    // R1: reset again
    rst_n = 0; @(negedge clk);
    chk("R1 tx", tx_ts0, 0); chk("R1 rx_sa", rx_sa, 0); chk("R1 ra", ra_stat, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule